// File: doc/BRIEF.md
# Per-CPU Interrupt Level Aggregator

This block collects every interrupt source aimed at one processor and turns them into that processor's set of requested interrupt levels, 1 to 15. It keeps a 32-bit pending word. The upper fifteen bits of that word are soft interrupts, which software sets and clears through a small register port. Bit 15 is a sticky level-15 flag, set by a dedicated input. Bit 14 follows the per-CPU timer input. Hard interrupt levels arrive already routed from the system-level controller as a level vector.

The level vector is the OR of three sources: the hard levels, the soft bits shifted down by sixteen, and the level-15 and timer bits. The level-15 and timer bits reach the processor unless the global-disable input is high. The block also gives the number of the highest requested level. Software reads the pending word at word 0. The read view also shows the hard levels routed at that moment. Word 1 is the clear port and word 2 is the set port.

Top module: `cpu_irq_level_agg`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it, rdata_o, lvl_req_o and top_lvl_o are all zero and no pending bit is set.
- R2: A read request loads rdata_o at the next clock edge. rdata_o then holds that value until the next read. Word 0 returns the pending word: bits 31:17 are the soft bits, bit 15 is the level-15 flag OR hard level 15, bit 14 is the timer bit OR hard level 14, bits 13:1 are hard levels 13:1, and bits 16 and 0 are zero. Words 1, 2 and 3 read as zero. A write to word 3 changes nothing.
- R3: A write to word 2 ORs wdata_i[31:17] into the soft bits. All other data bits are ignored.
- R4: A write to word 1 clears the soft bits selected by wdata_i[31:17] and clears the level-15 flag when wdata_i[15] is set. The timer bit and the hard levels are not affected.
- R5: The timer bit (pending bit 14) takes the value of tmr_i at every clock edge.
- R6: If l15_i is high at a clock edge, the level-15 flag is set and stays set until a clear write removes it. When a clear write and l15_i arrive in the same cycle, the set wins.
- R7: Soft bit 17+k requests level 1+k, for k = 0 to 14.
- R8: The level-15 flag requests level 15 and the timer bit requests level 14 only while gdis_i is low. gdis_i has no effect on soft or hard levels.
- R9: hard_lvl_i[n] requests level n for n = 1 to 15. hard_lvl_i[0] is ignored.
- R10: top_lvl_o is the highest requested level, or 0 when lvl_req_o is zero.
- R11: lvl_req_o and top_lvl_o reflect the inputs and the register writes sampled at a clock edge, and they change at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| l15_i | input | 1 | Level-15 set input |
| tmr_i | input | 1 | Per-CPU timer input |
| gdis_i | input | 1 | Global disable of the level-15 and timer requests |
| hard_lvl_i | input | 16 | Routed hard level vector (bit 0 unused) |
| lvl_req_o | output | 15 | Requested levels, bit n = level n |
| top_lvl_o | output | 4 | Highest requested level, 0 if none |

## Verification
The assertions check properties that hold on every cycle:
- The timer bit tracks tmr_i.
- The level-15 flag is set whenever l15_i was high.
- The selected soft bits are present after a set and absent after a clear.
- Reserved words read as zero.
- The encoder output always points at a set level with nothing above it.
- Global disable leaves level 14 equal to its soft and hard sources.

Only the bench scenarios can show the following:
- The exact composition of the read view, including the hard bits and the forced-zero bits.
- The priority of a set over a simultaneous clear.
- That ignored data bits and word-3 writes leave the state untouched.
- Agreement with an independent model over long mixed sequences.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned LVL_N    = 16;
  localparam int unsigned LVL_W    = $clog2(LVL_N);
  localparam int unsigned SOFT_LSB = 17;
  localparam int unsigned SOFT_W   = DATA_W - SOFT_LSB;
  localparam int unsigned L15_BIT  = 15;
  localparam int unsigned TMR_BIT  = 14;
  localparam int unsigned W_STATUS = 0;
  localparam int unsigned W_CLR    = 1;
  localparam int unsigned W_SET    = 2;
endpackage

// File: rtl/cpu_irq_pend_reg.sv
module cpu_irq_pend_reg
  import cpu_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 l15_i,
  input  logic                 tmr_i,
  input  logic [LVL_N-1:0]     hard_lvl_i,
  output logic [SOFT_W-1:0]    soft_d_o,
  output logic                 l15_d_o,
  output logic                 tmr_d_o,
  output logic [LVL_N-1:0]     hard_d_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(W_STATUS);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(W_CLR);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(W_SET);

  logic [SOFT_W-1:0] soft_q, soft_d;
  logic              l15_q, l15_d, tmr_q;
  logic [LVL_N-1:0]  hard_q, hard_d;
  logic [DATA_W-1:0] view, rdata_q;
  logic              wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;
  assign hard_d = {hard_lvl_i[LVL_N-1:1], 1'b0};

  always_comb begin
    soft_d = soft_q;
    l15_d  = l15_q;
    if (wr && addr_i == A_SET) soft_d = soft_q | wdata_i[DATA_W-1:SOFT_LSB];
    if (wr && addr_i == A_CLR) begin
      soft_d = soft_q & ~wdata_i[DATA_W-1:SOFT_LSB];
      if (wdata_i[L15_BIT]) l15_d = 1'b0;
    end
    if (l15_i) l15_d = 1'b1;  // set beats clear
  end

  always_comb begin
    view = '0;
    view[DATA_W-1:SOFT_LSB] = soft_q;
    view[LVL_N-1:0]         = hard_q;
    view[L15_BIT]           = hard_q[L15_BIT] | l15_q;
    view[TMR_BIT]           = hard_q[TMR_BIT] | tmr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_q  <= '0;
      l15_q   <= 1'b0;
      tmr_q   <= 1'b0;
      hard_q  <= '0;
      rdata_q <= '0;
    end else begin
      soft_q <= soft_d;
      l15_q  <= l15_d;
      tmr_q  <= tmr_i;
      hard_q <= hard_d;
      if (rd) rdata_q <= (addr_i == A_STATUS) ? view : '0;
    end
  end

  assign soft_d_o = soft_d;
  assign l15_d_o  = l15_d;
  assign tmr_d_o  = tmr_i;
  assign hard_d_o = hard_d;
  assign rdata_o  = rdata_q;

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[SOFT_LSB-1:L15_BIT+1], wdata_i[L15_BIT-1:0], hard_lvl_i[0]};

  p_tmr_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tmr_q == $past(tmr_i));
  p_l15_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l15_i |=> l15_q);
  p_soft_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_SET) |=> (soft_q & $past(wdata_i[DATA_W-1:SOFT_LSB])) == $past(wdata_i[DATA_W-1:SOFT_LSB]));
  p_soft_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_CLR) |=> (soft_q & $past(wdata_i[DATA_W-1:SOFT_LSB])) == '0);
  p_rsvd_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i != A_STATUS) |=> rdata_o == '0);
endmodule

// File: rtl/cpu_irq_lvl_comb.sv
module cpu_irq_lvl_comb
  import cpu_irq_pkg::*;
(
  input  logic [SOFT_W-1:0] soft_i,
  input  logic              l15_i,
  input  logic              tmr_i,
  input  logic              gdis_i,
  input  logic [LVL_N-1:0]  hard_i,
  output logic [LVL_N-1:0]  lvl_o
);
  logic [LVL_N-1:0] soft_lvl, gated;

  assign lvl_o[0]    = 1'b0;
  assign soft_lvl[0] = 1'b0;

  for (genvar k = 0; k < LVL_N - 1; k++) begin : g_soft
    if (k < SOFT_W) begin : g_map
      assign soft_lvl[k+1] = soft_i[k];
    end else begin : g_none
      assign soft_lvl[k+1] = 1'b0;
    end
  end

  always_comb begin
    gated = '0;
    gated[L15_BIT] = l15_i & ~gdis_i;
    gated[TMR_BIT] = tmr_i & ~gdis_i;
  end

  for (genvar n = 1; n < LVL_N; n++) begin : g_or
    assign lvl_o[n] = hard_i[n] | soft_lvl[n] | gated[n];
  end

  logic unused_hard0;
  assign unused_hard0 = hard_i[0] ^ soft_lvl[0];
endmodule

// File: rtl/cpu_irq_prio_enc.sv
module cpu_irq_prio_enc #(
  parameter int unsigned N = 16,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 1; i < int'(N); i++) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end

  logic unused_b0;
  assign unused_b0 = vec_i[0];
endmodule

// File: rtl/cpu_irq_level_agg.sv
module cpu_irq_level_agg
  import cpu_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 l15_i,
  input  logic                 tmr_i,
  input  logic                 gdis_i,
  input  logic [LVL_N-1:0]     hard_lvl_i,
  output logic [LVL_N-1:1]     lvl_req_o,
  output logic [LVL_W-1:0]     top_lvl_o
);
  logic [SOFT_W-1:0] soft_d;
  logic              l15_d, tmr_d;
  logic [LVL_N-1:0]  hard_d, lvl_d;
  logic [LVL_W-1:0]  top_d;
  logic [LVL_N-1:1]  lvl_q;
  logic [LVL_W-1:0]  top_q;

  cpu_irq_pend_reg #(.ADDR_W(ADDR_W)) u_pend (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .l15_i, .tmr_i, .hard_lvl_i,
    .soft_d_o(soft_d), .l15_d_o(l15_d), .tmr_d_o(tmr_d), .hard_d_o(hard_d),
    .rdata_o(rdata_o)
  );

  cpu_irq_lvl_comb u_comb (
    .soft_i(soft_d), .l15_i(l15_d), .tmr_i(tmr_d), .gdis_i(gdis_i),
    .hard_i(hard_d), .lvl_o(lvl_d)
  );

  cpu_irq_prio_enc #(.N(LVL_N), .W(LVL_W)) u_enc (
    .vec_i(lvl_d), .idx_o(top_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      top_q <= '0;
    end else begin
      lvl_q <= lvl_d[LVL_N-1:1];
      top_q <= top_d;
    end
  end

  assign lvl_req_o = lvl_q;
  assign top_lvl_o = top_q;

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_req_o == '0) |-> (top_lvl_o == '0));
  p_top_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_lvl_o != '0) |-> lvl_req_o[top_lvl_o]);
  p_no_higher_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((LVL_N'({lvl_req_o, 1'b0}) >> top_lvl_o) >> 1) == '0);
  p_gdis_tmr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gdis_i |=> lvl_req_o[TMR_BIT] == ($past(hard_lvl_i[TMR_BIT]) | rdata_bit_soft14));

  logic rdata_bit_soft14;
  assign rdata_bit_soft14 = u_pend.soft_q[TMR_BIT-1];
endmodule

// File: tb/cpu_irq_level_agg_test.sv
module cpu_irq_level_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        l15 = 1'b0, tmr = 1'b0, gdis = 1'b0;
  logic [15:0] hard = '0;
  logic [31:0] rdata;
  logic [15:1] lvl;
  logic [3:0]  top;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R11";

  always #5 clk = ~clk;

  cpu_irq_level_agg uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .l15_i(l15), .tmr_i(tmr), .gdis_i(gdis),
    .hard_lvl_i(hard), .lvl_req_o(lvl), .top_lvl_o(top)
  );

  // behavioural reference
  logic [14:0] m_soft;
  bit          m_l15, m_tmr;
  logic [15:0] m_hard, m_lvl;
  logic [31:0] m_rd;
  int          m_top;

  function automatic logic [31:0] m_view();
    logic [31:0] v;
    v = {m_soft, 17'd0} | {16'd0, m_hard};
    if (m_l15) v[15] = 1'b1;
    if (m_tmr) v[14] = 1'b1;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_soft = '0; m_l15 = 0; m_tmr = 0; m_hard = '0; m_lvl = '0; m_rd = '0; m_top = 0;
    end else begin
      if (req && !we) m_rd = (addr == 2'd0) ? m_view() : 32'd0;
      if (req && we && addr == 2'd2) m_soft = m_soft | wdata[31:17];
      if (req && we && addr == 2'd1) begin
        m_soft = m_soft & ~wdata[31:17];
        if (wdata[15]) m_l15 = 0;
      end
      if (l15) m_l15 = 1;
      m_tmr = tmr;
      m_hard = hard & 16'hFFFE;
      m_lvl = m_hard | {m_soft, 1'b0};
      if (!gdis) begin
        if (m_l15) m_lvl[15] = 1'b1;
        if (m_tmr) m_lvl[14] = 1'b1;
      end
      m_top = 0;
      for (int i = 1; i < 16; i++) if (m_lvl[i]) m_top = i;
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R2 rdata vs model", rdata, m_rd);
    chk({tag, " R9 lvl vs model"}, {17'd0, lvl}, {17'd0, m_lvl[15:1]});
    chk("R10 top vs model", {28'd0, top}, 32'(m_top));
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d; step(); req = 0; we = 0;
  endtask

  task automatic rd(logic [1:0] a);
    req = 1; we = 0; addr = a; step(); req = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    repeat (3) step();
    chk("R1 lvl in reset", {17'd0, lvl}, 0);
    chk("R1 top in reset", {28'd0, top}, 0);
    chk("R1 rdata in reset", rdata, 0);
    rst_n = 1; rd(0);
    chk("R1 pending after reset", rdata, 0);

    tag = "R7";
    wr(2, 32'hFFFF_FFFF);
    chk("R3 R7 all soft levels", {17'd0, lvl}, 32'h7FFF);
    chk("R3 top after set", {28'd0, top}, 15);
    rd(0);
    chk("R3 set limited to soft bits", rdata, 32'hFFFE_0000);

    tag = "R4";
    tmr = 1;
    wr(1, 32'h7FFE_4000);
    chk("R11 R4 lvl after clear", {17'd0, lvl}, 32'h6000);
    rd(0);
    chk("R4 timer kept by clear", rdata, 32'h8000_4000);
    tmr = 0;
    wr(1, 32'h8000_0000);
    rd(0);
    chk("R5 timer low clears", rdata, 0);
    chk("R10 idle top", {28'd0, top}, 0);

    tag = "R6";
    wr(2, 32'h0002_0000);
    chk("R7 bit17 level1", {17'd0, lvl}, 1);
    l15 = 1; step(); l15 = 0; step();
    rd(0);
    chk("R6 sticky l15", rdata, 32'h0002_8000);
    l15 = 1; wr(1, 32'h0000_8000); l15 = 0;
    rd(0);
    chk("R6 set beats clear", rdata, 32'h0002_8000);
    wr(1, 32'h0000_8000);
    rd(0);
    chk("R6 cleared", rdata, 32'h0002_0000);

    tag = "R8";
    l15 = 1; tmr = 1; gdis = 1; step(); l15 = 0;
    chk("R8 gated levels", {17'd0, lvl}, 1);
    chk("R8 gated top", {28'd0, top}, 1);
    gdis = 0; step();
    chk("R8 ungated top", {28'd0, top}, 15);
    tmr = 0; wr(1, 32'hFFFF_FFFF);

    tag = "R9";
    hard = 16'h0021; step();
    chk("R9 hard level5 bit0 ignored", {17'd0, lvl}, 32'h0010);
    chk("R9 top5", {28'd0, top}, 5);
    rd(0);
    chk("R2 view shows hard", rdata, 32'h0000_0020);
    rd(3);
    chk("R2 reserved read zero", rdata, 0);
    wr(3, 32'hFFFF_FFFF);
    rd(0);
    chk("R2 word3 write ignored", rdata, 32'h0000_0020);
    hard = 0;

    tag = "R11";
    for (int n = 0; n < 600; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      req = seed[31]; we = seed[30]; addr = seed[29:28];
      wdata = {seed[27:12], seed[15:0]} ^ {seed[11:0], 20'h5A5A5};
      l15 = (seed[9:7] == 3'd0); tmr = seed[6]; gdis = seed[5];
      hard = seed[23:8] & {16{seed[4]}};
      step();
    end
    req = 0;
    step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule